// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a serial slave that lets a host read and write a bank of 64 byte-wide configuration registers. The host uses four signals: a serial clock, an active-low select, a data line that the slave can turn around for read data, and an optional dedicated data output. The serial clock, select and data are brought into the system clock domain through two-flop synchronizers, and the clock edges are detected there.

Every transaction starts with an 8-bit header. For writes, the data bytes that follow land in consecutive registers until the select is raised. For reads, exactly one byte comes back per transaction. One group of adjacent registers forms a wider big-endian value. The upper bytes of that group wait in shadow storage and all bytes of the group change together. Three registers in the bank control the serial port itself: one enables readback, one selects the 4-wire mode, and one three-states the dedicated output.

Other logic can watch the committed register values through a registered parallel read port.

Top module: `cfg_spi_slave`

## Requirements
- R1: After reset, every register reads 0x00 on the parallel port, `sdio_oe` is 0, `sdo_oe` is 1 and `sdo_o` is 0.
- R2: The header is sampled MSB first on rising serial clock edges. Header bit 7 is the direction (1 = read, 0 = write), bits 6 to 1 are the register address (bit 6 = address MSB), and the value of bit 0 has no effect.
- R3: In a write, the 8 bits after the header are sampled MSB first on rising edges and stored in the addressed register. The new value appears on `rd_data` one system clock after `rd_addr` selects it.
- R4: In a write, each further complete byte goes to the next address while select stays low. The address after 0x3F is 0x00.
- R5: If select rises before the 8th bit of a byte has been sampled, that byte changes no register. Earlier complete bytes of the same burst remain written.
- R6: Registers 0x10 (most significant), 0x11 and 0x12 (least significant) form one 24-bit value. Writes to 0x10 and 0x11 leave their committed values unchanged. A write to 0x12 commits all three bytes at once, using the latest bytes written to 0x10 and 0x11.
- R7: In a read, the addressed register is returned MSB first on `sdio_o`. The first bit changes after the falling edge that follows the header's last rising edge, and each later bit changes after the next falling edge. Further clock cycles in the same transaction return nothing more and write no register.
- R8: A read is honoured only when bit 3 of register 0x3A is 1 or 4-wire mode is active. Otherwise `sdio_oe` stays 0 for the whole transaction.
- R9: `sdio_oe` is 0 whenever the select is high. During a write it is also 0.
- R10: 4-wire mode is active when bit 7 of register 0x19 is 1 and register 0x3A is 0x00. In this mode an honoured read also appears on `sdo_o`, with the same timing as `sdio_o`. In every other case `sdo_o` stays 0.
- R11: `sdo_oe` is 0 while bit 3 of register 0x3B is 1, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low transaction select |
| sdio_i | input | 1 | Serial data into the slave |
| sdio_o | output | 1 | Read data driven onto the shared data line |
| sdio_oe | output | 1 | Drive enable for the shared data line |
| sdo_o | output | 1 | Dedicated serial data output |
| sdo_oe | output | 1 | Drive enable for the dedicated output |
| rd_addr | input | 6 | Parallel read port address |
| rd_data | output | 8 | Registered committed value at `rd_addr` |

## Verification
The assertions assume that the serial clock changes slowly enough for the synchronizers to see every level: each half period lasts several system clocks. They also assume that the select changes well away from serial clock edges and that the data input is stable at each rising edge. The bench holds each serial clock level for 8 system clocks. It changes data only while the serial clock is low and keeps the select still for a full half period on either side of a transaction. Under these conditions, mode changes happen only in write transactions, so the gating checks on the read outputs never see a mode change in the middle of a read.

// File: rtl/cfg_spi_pkg.sv
package cfg_spi_pkg;
  localparam int DATA_W      = 8;
  localparam int ADDR_W      = 6;
  // control registers that steer the serial port itself
  localparam int MODE_REG    = 'h19;
  localparam int FOURW_BIT   = 7;
  localparam int RDCTL_REG   = 'h3A;
  localparam int RDEN_BIT    = 3;
  localparam int OUTCTL_REG  = 'h3B;
  localparam int TRI_BIT     = 3;
  // one big-endian multibyte register group
  localparam int MB_BASE     = 'h10;
  localparam int MB_LEN      = 3;
  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/cfg_spi_sync.sv
module cfg_spi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  input  logic sdi,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_idle,
  output logic sdi_s
);
  localparam int NSIG = 3;
  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] synced;
  logic            sck_d;

  assign raw = {sdi, cs_n, sck};

  for (genvar g = 0; g < NSIG; g++) begin : g_sync
    localparam logic INIT = (g == 1);
    logic [STAGES-1:0] ff;
    always_ff @(posedge clk) begin
      if (rst) ff <= {STAGES{INIT}};
      else     ff <= {ff[STAGES-2:0], raw[g]};
    end
    assign synced[g] = ff[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) sck_d <= 1'b0;
    else     sck_d <= synced[0];
  end

  assign sck_rise = synced[0] & ~sck_d;
  assign sck_fall = ~synced[0] & sck_d;
  assign cs_idle  = synced[1];
  assign sdi_s    = synced[2];
endmodule

// File: rtl/cfg_spi_shifter.sv
module cfg_spi_shifter #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              cs_idle,
  input  logic              sdi,
  input  logic              rd_ok,
  input  logic              four_wire,
  input  logic [DATA_W-1:0] rd_byte,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              sdio_o,
  output logic              sdio_oe,
  output logic              sdo_o
);
  localparam int CNT_W  = $clog2(DATA_W);
  localparam int RCNT_W = CNT_W + 1;
  localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [RCNT_W-1:0] RD_BITS  = RCNT_W'(DATA_W);

  logic [DATA_W-2:0] sr;
  logic [DATA_W-1:0] full;
  logic [CNT_W-1:0]  cnt;
  logic [RCNT_W-1:0] rd_cnt;
  logic [DATA_W-1:0] rd_sr;
  logic              in_data;
  logic              rd_act;
  logic              rd_en;
  logic              fw_q;
  logic              ld_pend;

  assign full = {sr, sdi};

  always_ff @(posedge clk) begin
    if (rst || cs_idle) begin
      sr       <= '0;
      cnt      <= '0;
      in_data  <= 1'b0;
      rd_act   <= 1'b0;
      rd_en    <= 1'b0;
      fw_q     <= 1'b0;
      ld_pend  <= 1'b0;
      rd_cnt   <= '0;
      rd_sr    <= '0;
      wr_en    <= 1'b0;
      sdio_o   <= 1'b0;
      sdio_oe  <= 1'b0;
      sdo_o    <= 1'b0;
      if (rst) begin
        cur_addr <= '0;
        wr_addr  <= '0;
        wr_data  <= '0;
      end
    end else begin
      wr_en   <= 1'b0;
      ld_pend <= 1'b0;
      if (ld_pend) rd_sr <= rd_byte;

      if (sck_rise && !rd_act) begin
        sr <= full[DATA_W-2:0];
        if (cnt == LAST_BIT) begin
          cnt <= '0;
          if (!in_data) begin
            in_data  <= 1'b1;
            cur_addr <= full[ADDR_W:1];
            if (full[DATA_W-1]) begin
              rd_act  <= 1'b1;
              rd_en   <= rd_ok;
              fw_q    <= four_wire;
              ld_pend <= 1'b1;
            end
          end else begin
            wr_en    <= 1'b1;
            wr_addr  <= cur_addr;
            wr_data  <= full;
            cur_addr <= cur_addr + 1'b1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end

      if (sck_fall && rd_act && (rd_cnt < RD_BITS)) begin
        rd_cnt  <= rd_cnt + 1'b1;
        rd_sr   <= {rd_sr[DATA_W-2:0], 1'b0};
        sdio_o  <= rd_en & rd_sr[DATA_W-1];
        sdio_oe <= rd_en;
        sdo_o   <= rd_en & fw_q & rd_sr[DATA_W-1];
      end
    end
  end
endmodule

// File: rtl/cfg_spi_regbank.sv
module cfg_spi_regbank #(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 6,
  parameter int MB_BASE = 'h10,
  parameter int MB_LEN  = 3
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [DATA_W-1:0]              wr_data,
  input  logic [ADDR_W-1:0]              spi_addr,
  output logic [DATA_W-1:0]              spi_data,
  input  logic [ADDR_W-1:0]              rd_addr,
  output logic [DATA_W-1:0]              rd_data,
  output logic                           fourw_bit,
  output logic                           rdctl_zero,
  output logic                           rden_bit,
  output logic                           tri_bit,
  output logic [(MB_LEN-1)*DATA_W-1:0]   mb_upper
);
  import cfg_spi_pkg::*;
  localparam int NREG = 1 << ADDR_W;
  localparam int NSHD = MB_LEN - 1;
  localparam logic [ADDR_W-1:0] LSB_ADDR = ADDR_W'(MB_BASE + MB_LEN - 1);

  logic [DATA_W-1:0] regs   [NREG];
  logic [DATA_W-1:0] shadow [NSHD];
  logic              is_upper;

  always_comb begin
    is_upper = 1'b0;
    for (int k = 0; k < NSHD; k++)
      if (wr_addr == ADDR_W'(MB_BASE + k)) is_upper = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      for (int k = 0; k < NSHD; k++) shadow[k] <= '0;
    end else if (wr_en) begin
      if (is_upper) begin
        for (int k = 0; k < NSHD; k++)
          if (wr_addr == ADDR_W'(MB_BASE + k)) shadow[k] <= wr_data;
      end else if (wr_addr == LSB_ADDR) begin
        regs[LSB_ADDR] <= wr_data;
        for (int k = 0; k < NSHD; k++) regs[MB_BASE + k] <= shadow[k];
      end else begin
        regs[wr_addr] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= regs[rd_addr];
  end

  assign spi_data   = regs[spi_addr];
  assign fourw_bit  = regs[MODE_REG][FOURW_BIT];
  assign rdctl_zero = (regs[RDCTL_REG] == '0);
  assign rden_bit   = regs[RDCTL_REG][RDEN_BIT];
  assign tri_bit    = regs[OUTCTL_REG][TRI_BIT];

  for (genvar k = 0; k < NSHD; k++) begin : g_mbup
    assign mb_upper[(NSHD-1-k)*DATA_W +: DATA_W] = regs[MB_BASE + k];
  end
endmodule

// File: rtl/cfg_spi_slave.sv
module cfg_spi_slave #(
  parameter int DATA_W      = cfg_spi_pkg::DATA_W,
  parameter int ADDR_W      = cfg_spi_pkg::ADDR_W,
  parameter int MB_BASE     = cfg_spi_pkg::MB_BASE,
  parameter int MB_LEN      = cfg_spi_pkg::MB_LEN,
  parameter int SYNC_STAGES = cfg_spi_pkg::SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              sdio_i,
  output logic              sdio_o,
  output logic              sdio_oe,
  output logic              sdo_o,
  output logic              sdo_oe,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic                         sck_rise, sck_fall, cs_idle, sdi_s;
  logic [ADDR_W-1:0]            cur_addr, wr_addr;
  logic [DATA_W-1:0]            wr_data, spi_data;
  logic                         wr_en;
  logic                         fourw_bit, rdctl_zero, rden_bit, tri_bit;
  logic                         four_wire, rd_ok;
  logic [(MB_LEN-1)*DATA_W-1:0] mb_upper;

  cfg_spi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .sdi(sdio_i),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_idle(cs_idle), .sdi_s(sdi_s)
  );

  assign four_wire = fourw_bit & rdctl_zero;
  assign rd_ok     = four_wire | rden_bit;

  cfg_spi_shifter #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_shift (
    .clk(clk), .rst(rst), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .cs_idle(cs_idle), .sdi(sdi_s), .rd_ok(rd_ok), .four_wire(four_wire),
    .rd_byte(spi_data), .cur_addr(cur_addr), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .sdio_o(sdio_o),
    .sdio_oe(sdio_oe), .sdo_o(sdo_o)
  );

  cfg_spi_regbank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W),
                    .MB_BASE(MB_BASE), .MB_LEN(MB_LEN)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .spi_addr(cur_addr), .spi_data(spi_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .fourw_bit(fourw_bit),
    .rdctl_zero(rdctl_zero), .rden_bit(rden_bit), .tri_bit(tri_bit),
    .mb_upper(mb_upper)
  );

  always_ff @(posedge clk) begin
    if (rst) sdo_oe <= 1'b1;
    else     sdo_oe <= ~tri_bit;
  end
endmodule

// File: rtl/cfg_spi_slave_chk.sv
module cfg_spi_slave_chk #(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 6,
  parameter int MB_BASE = 'h10,
  parameter int MB_LEN  = 3
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         cs_idle,
  input logic                         wr_en,
  input logic [ADDR_W-1:0]            wr_addr,
  input logic                         sdio_oe,
  input logic                         sdo_o,
  input logic                         sdo_oe,
  input logic                         four_wire,
  input logic                         rd_ok,
  input logic                         tri_bit,
  input logic [(MB_LEN-1)*DATA_W-1:0] mb_upper
);
  localparam logic [ADDR_W-1:0] LSB_ADDR = ADDR_W'(MB_BASE + MB_LEN - 1);

  // R9
  oe_idle_chk: assert property (@(posedge clk) disable iff (rst)
    cs_idle |=> !sdio_oe);
  // R8
  rd_gate_chk: assert property (@(posedge clk) disable iff (rst)
    sdio_oe |-> rd_ok);
  // R10
  sdo_mode_chk: assert property (@(posedge clk) disable iff (rst)
    sdo_o |-> four_wire);
  // R5
  wr_frame_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !$past(cs_idle));
  // R6
  mb_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr == LSB_ADDR) |=> $stable(mb_upper));
  // R11
  tri_chk: assert property (@(posedge clk) disable iff (rst)
    tri_bit |=> !sdo_oe);
endmodule

bind cfg_spi_slave cfg_spi_slave_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MB_BASE(MB_BASE), .MB_LEN(MB_LEN)
) u_chk (
  .clk(clk), .rst(rst), .cs_idle(cs_idle), .wr_en(wr_en), .wr_addr(wr_addr),
  .sdio_oe(sdio_oe), .sdo_o(sdo_o), .sdo_oe(sdo_oe), .four_wire(four_wire),
  .rd_ok(rd_ok), .tri_bit(tri_bit), .mb_upper(mb_upper)
);

// File: tb/cfg_spi_slave_bench.sv
module cfg_spi_slave_bench;
  localparam int H = 8;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0, cs_n = 1'b1, sdio_i = 1'b0;
  logic sdio_o, sdio_oe, sdo_o, sdo_oe;
  logic [5:0] rd_addr = '0;
  logic [7:0] rd_data;

  int checks = 0, fails = 0;
  logic [7:0] mdl [64];
  logic [7:0] shd [2];

  always #5 clk = ~clk;

  cfg_spi_slave u_cfg_spi_slave (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .sdio_i(sdio_i),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo_o(sdo_o), .sdo_oe(sdo_oe),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int k);
    return 8'((k * 37 + 5) & 255);
  endfunction

  // model of a completed byte write (R3, R6)
  task automatic mdl_wr(input logic [5:0] a, input logic [7:0] d);
    if (a == 6'h10) shd[0] = d;
    else if (a == 6'h11) shd[1] = d;
    else if (a == 6'h12) begin
      mdl[6'h10] = shd[0]; mdl[6'h11] = shd[1]; mdl[6'h12] = d;
    end else mdl[a] = d;
  endtask

  task automatic sbit(input logic b);
    sdio_i = b; tick(H); sck = 1'b1; tick(H); sck = 1'b0;
  endtask

  task automatic sbyte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) sbit(v[i]);
  endtask

  task automatic cs_lo();
    cs_n = 1'b0; tick(H);
  endtask

  task automatic cs_hi();
    tick(H); cs_n = 1'b1; tick(2 * H);
  endtask

  task automatic wr1(input logic [5:0] a, input logic [7:0] d, input logic b0);
    cs_lo(); sbyte({1'b0, a, b0}); sbyte(d); cs_hi(); mdl_wr(a, d);
  endtask

  task automatic peek(input logic [5:0] a, output logic [7:0] v);
    rd_addr = a; tick(2); v = rd_data;
  endtask

  task automatic cmp_all(input string req);
    logic [7:0] v;
    for (int a = 0; a < 64; a++) begin
      peek(6'(a), v); chk(req, v, mdl[a]);
    end
  endtask

  task automatic spi_rd(input logic [5:0] a, input int extra,
                        output logic [7:0] got, output logic [7:0] sgot,
                        output logic oe_any, output logic oe_all);
    cs_lo(); sbyte({1'b1, a, 1'b0});
    oe_any = 1'b0; oe_all = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      sdio_i = 1'b1; tick(H);
      got[i] = sdio_o; sgot[i] = sdo_o;
      oe_any = oe_any | sdio_oe; oe_all = oe_all & sdio_oe;
      sck = 1'b1; tick(H); sck = 1'b0;
    end
    for (int i = 0; i < extra; i++) sbit(1'b1);
    cs_hi();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] v, g, s;
    logic oa, ol;
    for (int a = 0; a < 64; a++) mdl[a] = '0;
    shd[0] = '0; shd[1] = '0;
    tick(4); rst = 1'b0; tick(4);

    // R1 reset state
    chk("R1 sdio_oe", {7'd0, sdio_oe}, 8'd0);
    chk("R1 sdo_oe", {7'd0, sdo_oe}, 8'd1);
    chk("R1 sdo_o", {7'd0, sdo_o}, 8'd0);
    cmp_all("R1 reset regs");

    // R3 R4 burst from 0x3E with wrap, 66 bytes; R6 group committed in order
    cs_lo(); sbyte({1'b0, 6'h3E, 1'b0});
    for (int k = 0; k < 66; k++) begin
      sbyte(pat(k)); mdl_wr(6'((6'h3E + k) & 63), pat(k));
    end
    cs_hi();
    cmp_all("R4 burst wrap");

    // R6 multibyte hold then commit; R2 header bit0 set has no effect
    wr1(6'h10, 8'hA5, 1'b1); peek(6'h10, v); chk("R6 upper held", v, mdl[6'h10]);
    wr1(6'h11, 8'h5A, 1'b0); peek(6'h11, v); chk("R6 mid held", v, mdl[6'h11]);
    wr1(6'h12, 8'hC3, 1'b1);
    peek(6'h10, v); chk("R6 commit msb", v, 8'hA5);
    peek(6'h11, v); chk("R6 commit mid", v, 8'h5A);
    peek(6'h12, v); chk("R6 commit lsb", v, 8'hC3);
    wr1(6'h07, 8'h3C, 1'b1); peek(6'h07, v); chk("R2 bit0 ignored", v, 8'h3C);

    // R5 abort mid byte, and abort second byte of a burst
    cs_lo(); sbyte({1'b0, 6'h05, 1'b0});
    for (int i = 0; i < 5; i++) sbit(1'b1);
    cs_hi(); peek(6'h05, v); chk("R5 partial byte", v, mdl[6'h05]);
    cs_lo(); sbyte({1'b0, 6'h06, 1'b0}); sbyte(8'h96); mdl_wr(6'h06, 8'h96);
    for (int i = 0; i < 7; i++) sbit(1'b0);
    cs_hi();
    peek(6'h06, v); chk("R5 first byte kept", v, 8'h96);
    peek(6'h07, v); chk("R5 second dropped", v, 8'h3C);

    // R7 reads in 3-wire mode with readback on, all addresses
    wr1(6'h19, 8'h00, 1'b0); wr1(6'h3B, 8'h00, 1'b0); wr1(6'h3A, 8'h08, 1'b0);
    chk("R11 sdo_oe on", {7'd0, sdo_oe}, 8'd1);
    for (int a = 0; a < 64; a++) begin
      spi_rd(6'(a), 0, g, s, oa, ol);
      chk("R7 read data", g, mdl[a]);
      if (a % 16 == 0) begin
        chk("R8 oe held", {7'd0, ol}, 8'd1);
        chk("R10 sdo quiet 3-wire", s, 8'h00);
      end
    end
    chk("R9 oe released", {7'd0, sdio_oe}, 8'd0);

    // R7 no increment on reads: extra clocks write nothing
    spi_rd(6'h20, 16, g, s, oa, ol);
    chk("R7 single byte", g, mdl[6'h20]);
    peek(6'h20, v); chk("R7 addr untouched", v, mdl[6'h20]);
    peek(6'h21, v); chk("R7 next untouched", v, mdl[6'h21]);

    // R8 readback disabled, 3-wire
    wr1(6'h3A, 8'h00, 1'b0);
    spi_rd(6'h22, 0, g, s, oa, ol);
    chk("R8 read refused", {7'd0, oa}, 8'd0);
    chk("R9 oe during write", {7'd0, sdio_oe}, 8'd0);

    // R10 4-wire mode
    wr1(6'h19, 8'h80, 1'b0);
    spi_rd(6'h22, 0, g, s, oa, ol);
    chk("R10 sdo data", s, mdl[6'h22]);
    chk("R10 sdio data", g, mdl[6'h22]);
    wr1(6'h3A, 8'h08, 1'b0);
    spi_rd(6'h23, 0, g, s, oa, ol);
    chk("R10 not 4-wire sdo", s, 8'h00);
    chk("R10 3-wire sdio", g, mdl[6'h23]);

    // R11 three-state of dedicated output
    wr1(6'h3B, 8'h08, 1'b0); tick(2);
    chk("R11 tri set", {7'd0, sdo_oe}, 8'd0);
    wr1(6'h3B, 8'hF7, 1'b0); tick(2);
    chk("R11 tri clear", {7'd0, sdo_oe}, 8'd1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule